// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block produces the active-low reset for a processor from three digital sources. The first is a supply-below-threshold flag, which is already synchronous to the clock. The second is an active-low manual reset pin. The third is a watchdog input that the processor must keep toggling.

Any fault holds the reset low. When the last fault clears, the reset stays low for a fixed hold period, counted in clock cycles. The watchdog counter runs only while reset is released. Either edge on the watchdog input clears it. If the counter reaches its limit, the watchdog raises a one-cycle fault, which produces a reset pulse of one hold period.

A separate "float" input marks the watchdog line as undriven. While it is set, an internal service level replaces the pin. That level stays low for the first seven eighths of the watchdog period and then goes high. The resulting edge services the counter, so the watchdog never fires. Both periods are parameters, so a simulation can use short values.

Top module: `sup_rst_wdog`

## Requirements
- R1: While `supply_low_i` is sampled high at a clock edge, `rst_n_o` is low after that edge. Once the flag is sampled low, `rst_n_o` returns high exactly HOLD_CYC edges after the last edge that sampled it high.
- R2: If the supply flag is seen again while the hold period is counting, the count restarts from zero. The release then comes HOLD_CYC edges after the newest fault sample.
- R3: `mreset_n_i` passes through a two-flop synchronizer. A low level held across at least one rising edge asserts reset. The release comes HOLD_CYC edges after the second edge following the pin's return high.
- R4: If the effective watchdog level shows no edge, reset goes low exactly WDOG_CYC edges after the edge that released it. The resulting pulse lasts exactly HOLD_CYC cycles.
- R5: A rising or falling edge on the synchronized watchdog input clears the watchdog counter. Toggling the input at intervals shorter than WDOG_CYC cycles never causes a reset.
- R6: While reset is asserted, the watchdog counter is held at zero and does not count. After any release, the full WDOG_CYC cycles are available.
- R7: While `wdog_float_i` (synchronized) is high, the pin level is ignored. An internal level services the counter at seven eighths of the period, so no watchdog reset occurs.
- R8: While `arst_n` is low, `rst_n_o` is low. After `arst_n` is released with no faults present, `rst_n_o` goes high exactly HOLD_CYC edges later.
- R9: Every reset assertion, including one caused by a single-cycle trigger, lasts at least HOLD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low logic reset |
| supply_low_i | input | 1 | Synchronous supply-below-threshold flag |
| mreset_n_i | input | 1 | Asynchronous active-low manual reset |
| wdog_i | input | 1 | Asynchronous watchdog kick input |
| wdog_float_i | input | 1 | Asynchronous flag: watchdog line is undriven |
| rst_n_o | output | 1 | Active-low processor reset |

## Verification
The following properties are checked on every cycle:
- A fault forces reset on the next edge.
- The hold and watchdog counters stay within their limits.
- The hold counter is idle whenever reset is released.
- The watchdog counter is zeroed while reset is asserted.
- A release happens only from the final count with no fault present.

Exact reset widths and watchdog intervals span parameter-sized windows. The bench's scenarios therefore show these by counting edges. This covers the restart behaviour, the synchronizer latency of the manual input, and the absence of resets under regular toggling or with the line floating.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  // Point in the watchdog period at which the internal service level goes high
  function automatic int unsigned service_point(input int unsigned period);
    return period - (period / 8);
  endfunction
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q;
  logic [WIDTH-1:0] s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/srw_hold_timer.sv
module srw_hold_timer #(
  parameter int unsigned HOLD_CYC = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic fault_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (fault_i) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

  p_fault_asserts_r1: assert property (@(posedge clk) disable iff (!arst_n)
    fault_i |=> act_q);
  p_restart_r2: assert property (@(posedge clk) disable iff (!arst_n)
    fault_i |=> cnt_q == '0);
  p_release_at_end_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (act_q && !act_d) |-> (cnt_q == LAST && !fault_i));
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LAST);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!arst_n)
    !act_q |-> cnt_q == '0);
endmodule

// File: rtl/srw_wdog.sv
module srw_wdog
  import sup_rst_pkg::*;
#(
  parameter int unsigned WDOG_CYC = 32
) (
  input  logic clk,
  input  logic arst_n,
  input  logic kick_i,
  input  logic float_i,
  input  logic hold_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(WDOG_CYC);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYC - 1);
  localparam logic [CW-1:0] SVC  = CW'(service_point(WDOG_CYC));

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          svc_lvl, edge_w, fire_w;

  always_comb begin
    svc_lvl = (cnt_q >= SVC);
    lvl_d   = float_i ? svc_lvl : kick_i;
    edge_w  = lvl_d ^ lvl_q;
    fire_w  = (cnt_q == LAST) && !edge_w && !hold_i;
    if (hold_i || edge_w || fire_w) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign fire_o = fire_w;

  p_hold_clears_r6: assert property (@(posedge clk) disable iff (!arst_n)
    hold_i |=> cnt_q == '0);
  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (!float_i && kick_i != lvl_q) |=> cnt_q == '0);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LAST);
  p_fire_released_r4: assert property (@(posedge clk) disable iff (!arst_n)
    fire_o |-> !hold_i);
  p_service_edge_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (float_i && lvl_q == 1'b0 && cnt_q == SVC) |=> cnt_q == '0);
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog #(
  parameter int unsigned HOLD_CYC = 25_000_000,
  parameter int unsigned WDOG_CYC = 200_000_000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_low_i,
  input  logic mreset_n_i,
  input  logic wdog_i,
  input  logic wdog_float_i,
  output logic rst_n_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_w, syn_w;
  logic             mr_n_s, kick_s, float_s;
  logic             fire_w, fault_w, active_w;

  assign raw_w = {mreset_n_i, wdog_i, wdog_float_i};

  srw_sync #(.WIDTH(NSYNC), .RST_VAL(3'b100)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d_i    (raw_w),
    .q_o    (syn_w)
  );

  assign {mr_n_s, kick_s, float_s} = syn_w;

  srw_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk     (clk),
    .arst_n  (arst_n),
    .kick_i  (kick_s),
    .float_i (float_s),
    .hold_i  (active_w),
    .fire_o  (fire_w)
  );

  assign fault_w = supply_low_i | ~mr_n_s | fire_w;

  srw_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .arst_n   (arst_n),
    .fault_i  (fault_w),
    .active_o (active_w)
  );

  assign rst_n_o = ~active_w;

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!arst_n)
    supply_low_i |=> !rst_n_o);
  p_manual_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !mr_n_s |=> !rst_n_o);
endmodule

// File: tb/sup_rst_wdog_test.sv
module sup_rst_wdog_test;
  localparam int unsigned HOLD = 10;
  localparam int unsigned WDOG = 32;

  logic clk = 1'b0;
  logic arst_n, supply_low, mreset_n, wdog, wfloat;
  logic rst_n;
  logic tog_en = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  sup_rst_wdog #(.HOLD_CYC(HOLD), .WDOG_CYC(WDOG)) uut (
    .clk          (clk),
    .arst_n       (arst_n),
    .supply_low_i (supply_low),
    .mreset_n_i   (mreset_n),
    .wdog_i       (wdog),
    .wdog_float_i (wfloat),
    .rst_n_o      (rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count edges until rst_n reaches the given level
  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (rst_n !== lvl && n < 5000);
  endtask

  // toggler for the watchdog pin, every 8 cycles
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      if (tog_en) wdog = ~wdog;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, lows;
    arst_n = 1'b0; supply_low = 1'b0; mreset_n = 1'b1; wdog = 1'b0; wfloat = 1'b0;
    repeat (5) @(posedge clk);
    #1 chk(rst_n === 1'b0, "R8 reset state", rst_n, 0);
    tog_en = 1'b1;
    @(negedge clk); arst_n = 1'b1;
    edges_until(1'b1, n);
    chk(n == HOLD, "R8 release after logic reset", n, HOLD);

    // R5: regular kicks never reset
    lows = 0;
    repeat (150) begin @(posedge clk); #1; if (rst_n !== 1'b1) lows++; end
    chk(lows == 0, "R5 kicks prevent reset", lows, 0);

    // R1 / R9: supply-low sweep of lengths
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); supply_low = 1'b1;
      @(posedge clk); #1 chk(rst_n === 1'b0, "R1 supply low asserts", rst_n, 0);
      repeat (k - 1) @(negedge clk);
      @(negedge clk); supply_low = 1'b0;
      edges_until(1'b1, n);
      chk(n == HOLD, "R1/R9 hold after supply low", n, HOLD);
    end

    // R2: fault again mid-count restarts
    @(negedge clk); supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0;
    repeat (4) @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0;
    #1 chk(rst_n === 1'b0, "R2 still low mid-count", rst_n, 0);
    edges_until(1'b1, n);
    chk(n == HOLD, "R2 restart from newest fault", n, HOLD);

    // R3: manual reset sweep of lengths
    for (int h = 1; h <= 3; h++) begin
      @(negedge clk); mreset_n = 1'b0;
      repeat (h) @(negedge clk);
      mreset_n = 1'b1;
      repeat (2) @(posedge clk);
      #1 chk(rst_n === 1'b0, "R3 manual asserts", rst_n, 0);
      edges_until(1'b1, n);
      chk(n == HOLD, "R3 hold after manual release", n, HOLD);
    end

    // R6 / R4: stop kicks, long supply-low, then watchdog cycles
    tog_en = 1'b0;
    @(negedge clk); supply_low = 1'b1;
    repeat (3 * WDOG) @(negedge clk);
    supply_low = 1'b0;
    edges_until(1'b1, n);
    chk(n == HOLD, "R6 hold after long fault", n, HOLD);
    edges_until(1'b0, n);
    chk(n == WDOG, "R6/R4 full watchdog period after release", n, WDOG);
    edges_until(1'b1, n);
    chk(n == HOLD, "R4/R9 watchdog pulse width", n, HOLD);
    edges_until(1'b0, n);
    chk(n == WDOG, "R4 repeat watchdog period", n, WDOG);

    // R7: floating line, pin held constant, no more watchdog resets
    @(negedge clk); wfloat = 1'b1; wdog = 1'b1;
    edges_until(1'b1, n);
    chk(n == HOLD, "R7 release while floating", n, HOLD);
    lows = 0;
    repeat (8 * WDOG) begin @(posedge clk); #1; if (rst_n !== 1'b1) lows++; end
    chk(lows == 0, "R7 internal service prevents reset", lows, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule